// File: doc/BRIEF.md
# LAPS Receive Frame Decapsulator

This block takes a descrambled octet stream that carries flag-delimited LAPS frames and turns it into a stream of payload octets with start and end markers. It decodes the two-octet escape codes that hide flag and escape values inside a frame. It deletes rate-adaptation pairs as if they had never been sent. It checks the four header octets (address, control and a two-octet protocol identifier) against configured values, verifies the 32-bit frame check sequence and limits the frame length.

Every frame that carries content ends with a one-cycle status pulse on plain pins, with a cause code. A frame that is aborted or grows too long is cut off at once. Its remaining content is discarded up to the next flag, so a downstream packet store can drop it on the status code. The four check octets are never forwarded. To hold them back, the block delays the payload by five octets.

Both streams use valid/ready handshakes. An input octet is taken only when the output register is empty or is being emptied in the same cycle. While the output is stalled, input stays blocked and nothing is lost. An offered beat keeps its data and markers unchanged until it is accepted.

Top module: `laps_rx_decap`

## Requirements
- R1: A flag (0x7E) that follows another flag, or that follows an ended or discarded frame with no octet in between, is idle fill. It produces no beat and no status.
- R2: Inside a frame, 0x7D,0x5E decodes to one 0x7E octet and 0x7D,0x5D decodes to one 0x7D octet. Both count as one octet toward the length and the check sequence.
- R3: The pair 0x7D,0xDD is deleted. It adds nothing to the payload, the length or the check sequence.
- R4: 0x7D followed by 0x7E, or 0x7D followed by any octet other than 0x5E, 0x5D or 0xDD, aborts the frame. Status code 3 is reported in the cycle after that octet is taken, and everything up to the next flag is discarded. If payload beats were already sent, the oldest held octet is sent with the end marker.
- R5: The first four decoded octets are compared in order with cfg_addr, cfg_ctrl, cfg_sapi[15:8] and cfg_sapi[7:0]. On any mismatch the frame sends no beats and ends with status code 1.
- R6: The last four decoded octets before the closing flag are the check sequence. The CRC-32 (reflected polynomial 0xEDB88320, preset all ones) runs over the header and payload. Its complement is sent least significant octet first, and a correct frame leaves the residue 0xDEBB20E3. A good frame ends with code 0, a bad one with code 2. The check octets are never forwarded.
- R7: If a decoded octet would make the frame longer than cfg_max_len octets (header and check octets included), status code 4 is reported at once, the frame is discarded to the next flag, and an open payload is closed as in R4. A frame of exactly cfg_max_len octets is accepted.
- R8: Payload octets leave in order. The first has out_sop=1, and the last has out_eop=1 and appears in the same cycle as the status pulse. A one-octet payload carries both markers on one beat.
- R9: While out_valid=1 and out_ready=0, out_data, out_sop and out_eop hold and in_ready is 0.
- R10: After reset in_ready=1, out_valid=0 and st_valid=0.
- R11: A frame closed with fewer than four decoded octets ends with code 1. One with four to seven decoded octets and a good header ends with code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input octet offered |
| in_ready | output | 1 | Input octet accepted this cycle when in_valid is high |
| in_data | input | 8 | Descrambled line octet |
| out_valid | output | 1 | Payload beat offered |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | 8 | Payload octet |
| out_sop | output | 1 | First payload octet of a frame |
| out_eop | output | 1 | Last beat of a frame |
| st_valid | output | 1 | One-cycle end-of-frame status pulse |
| st_code | output | 3 | 0 good, 1 header, 2 check sequence, 3 abort, 4 oversize |
| cfg_addr | input | 8 | Expected address octet |
| cfg_ctrl | input | 8 | Expected control octet |
| cfg_sapi | input | 16 | Expected protocol identifier, high octet first |
| cfg_max_len | input | LEN_W | Largest allowed frame length in decoded octets |

## Verification
The closing beat and the status pulse are produced by the same accepted octet. That octet is a closing flag, an abort escape or the octet that breaks the length limit. The bench ends good, bad-check, aborted and oversized frames with payload already in flight, and requires the status to arrive with a last beat that holds exactly the expected octet. Frames are also sent while out_ready toggles. This stalls the output, so the closing octet must wait at the input, and the order and markers of the beats are then compared against a list built in the bench.

// File: rtl/laps_rx_pkg.sv
package laps_rx_pkg;
  localparam logic [7:0] OCT_FLAG   = 8'h7E;
  localparam logic [7:0] OCT_ESC    = 8'h7D;
  localparam logic [7:0] ESC_2_FLAG = 8'h5E;
  localparam logic [7:0] ESC_2_ESC  = 8'h5D;
  localparam logic [7:0] ESC_2_FILL = 8'hDD;

  localparam logic [31:0] CRC_PRESET  = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB_20E3;
  localparam logic [31:0] CRC_POLY_R  = 32'hEDB8_8320;

  localparam int HDR_OCTETS = 4;
  localparam int FCS_OCTETS = 4;

  typedef enum logic [2:0] {
    ST_GOOD     = 3'd0,
    ST_HEADER   = 3'd1,
    ST_CHECK    = 3'd2,
    ST_ABORT    = 3'd3,
    ST_OVERSIZE = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    TK_NONE,
    TK_FLAG,
    TK_DATA,
    TK_ABORT
  } tok_e;
endpackage

// File: rtl/laps_rx_unesc.sv
module laps_rx_unesc
  import laps_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic [7:0] oct_i,
  output tok_e       tok_o,
  output logic [7:0] data_o
);
  logic esc_q;
  logic esc_d;

  always_comb begin
    tok_o  = TK_NONE;
    data_o = oct_i;
    esc_d  = 1'b0;
    if (esc_q) begin
      unique case (oct_i)
        ESC_2_FLAG: begin tok_o = TK_DATA; data_o = OCT_FLAG; end
        ESC_2_ESC:  begin tok_o = TK_DATA; data_o = OCT_ESC;  end
        ESC_2_FILL: tok_o = TK_NONE;
        default:    tok_o = TK_ABORT;
      endcase
    end else if (oct_i == OCT_FLAG) begin
      tok_o = TK_FLAG;
    end else if (oct_i == OCT_ESC) begin
      esc_d = 1'b1;
    end else begin
      tok_o = TK_DATA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    esc_q <= 1'b0;
    else if (step) esc_q <= esc_d;
  end
endmodule

// File: rtl/laps_rx_crc32.sv
module laps_rx_crc32
  import laps_rx_pkg::*;
#(
  parameter logic [31:0] POLY = CRC_POLY_R
) (
  input  logic [31:0] crc_i,
  input  logic [7:0]  oct_i,
  output logic [31:0] crc_o
);
  always_comb begin
    crc_o = crc_i;
    for (int i = 0; i < 8; i++) begin
      if (crc_o[0] ^ oct_i[i]) crc_o = (crc_o >> 1) ^ POLY;
      else                     crc_o = crc_o >> 1;
    end
  end
endmodule

// File: rtl/laps_rx_hold.sv
module laps_rx_hold #(
  parameter int W     = 8,
  parameter int DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic [W-1:0] oldest,
  output logic         full
);
  localparam int FW = $clog2(DEPTH + 1);

  logic [W-1:0]  stg [DEPTH];
  logic [FW-1:0] fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else if (clr) begin
      fill_q <= '0;
    end else if (push) begin
      stg[0] <= din;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
      if (fill_q != FW'(DEPTH)) fill_q <= fill_q + 1'b1;
    end
  end

  assign oldest = stg[DEPTH-1];
  assign full   = (fill_q == FW'(DEPTH));
endmodule

// File: rtl/laps_rx_decap.sv
module laps_rx_decap
  import laps_rx_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic             st_valid,
  output logic [2:0]       st_code,
  input  logic [7:0]       cfg_addr,
  input  logic [7:0]       cfg_ctrl,
  input  logic [15:0]      cfg_sapi,
  input  logic [LEN_W-1:0] cfg_max_len
);
  localparam int             DLY    = FCS_OCTETS + 1;
  localparam logic [LEN_W-1:0] HDR_N = LEN_W'(HDR_OCTETS);
  localparam logic [LEN_W-1:0] MIN_N = LEN_W'(HDR_OCTETS + FCS_OCTETS);

  logic             fire;
  tok_e             tok;
  logic [7:0]       dec;
  logic [31:0]      crc_q, crc_nx;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W:0]   cnt_p1;
  logic             bad_q, sop_q, drop_q;
  logic [7:0]       hdr_exp;
  logic [7:0]       oldest;
  logic             full;

  logic   emit, e_sop, e_eop, st_fire;
  cause_e st_c;
  logic   clr, push, upd, set_bad, set_sop, drop_set, drop_clr;

  assign fire     = in_valid && in_ready;
  assign in_ready = !out_valid || out_ready;
  assign cnt_p1   = {1'b0, cnt_q} + 1'b1;

  laps_rx_unesc u_unesc (
    .clk(clk), .rst_n(rst_n), .step(fire), .oct_i(in_data),
    .tok_o(tok), .data_o(dec)
  );

  laps_rx_crc32 u_crc (.crc_i(crc_q), .oct_i(dec), .crc_o(crc_nx));

  laps_rx_hold #(.W(8), .DEPTH(DLY)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .din(dec),
    .oldest(oldest), .full(full)
  );

  always_comb begin
    unique case (cnt_q[1:0])
      2'd0:    hdr_exp = cfg_addr;
      2'd1:    hdr_exp = cfg_ctrl;
      2'd2:    hdr_exp = cfg_sapi[15:8];
      default: hdr_exp = cfg_sapi[7:0];
    endcase
  end

  // Per accepted octet: decide beat, status and frame state changes.
  always_comb begin
    emit = 1'b0; e_sop = 1'b0; e_eop = 1'b0;
    st_fire = 1'b0; st_c = ST_GOOD;
    clr = 1'b0; push = 1'b0; upd = 1'b0; set_bad = 1'b0; set_sop = 1'b0;
    drop_set = 1'b0; drop_clr = 1'b0;
    if (fire) begin
      unique case (tok)
        TK_DATA: if (!drop_q) begin
          if (cnt_p1 > {1'b0, cfg_max_len}) begin
            st_fire = 1'b1; st_c = ST_OVERSIZE;
            drop_set = 1'b1; clr = 1'b1;
            if (sop_q) begin emit = 1'b1; e_eop = 1'b1; end
          end else begin
            upd = 1'b1;
            if (cnt_q < HDR_N) begin
              if (dec != hdr_exp) set_bad = 1'b1;
            end else begin
              push = 1'b1;
              if (full && !bad_q) begin
                emit = 1'b1; e_sop = !sop_q; set_sop = 1'b1;
              end
            end
          end
        end
        TK_ABORT: if (!drop_q) begin
          st_fire = 1'b1; st_c = ST_ABORT;
          drop_set = 1'b1; clr = 1'b1;
          if (sop_q) begin emit = 1'b1; e_eop = 1'b1; end
        end
        TK_FLAG: begin
          if (drop_q) begin
            drop_clr = 1'b1;
          end else if (cnt_q != '0) begin
            st_fire = 1'b1; clr = 1'b1;
            if (cnt_q < HDR_N || bad_q)                 st_c = ST_HEADER;
            else if (cnt_q < MIN_N || crc_q != CRC_RESIDUE) st_c = ST_CHECK;
            else                                        st_c = ST_GOOD;
            if (full && !bad_q) begin
              emit = 1'b1; e_eop = 1'b1; e_sop = !sop_q;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; crc_q <= CRC_PRESET; bad_q <= 1'b0; sop_q <= 1'b0;
      drop_q <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; out_sop <= 1'b0; out_eop <= 1'b0;
      st_valid <= 1'b0; st_code <= '0;
    end else begin
      if (clr) begin
        cnt_q <= '0; crc_q <= CRC_PRESET; bad_q <= 1'b0; sop_q <= 1'b0;
      end else begin
        if (upd)     begin cnt_q <= cnt_p1[LEN_W-1:0]; crc_q <= crc_nx; end
        if (set_bad) bad_q <= 1'b1;
        if (set_sop) sop_q <= 1'b1;
      end
      if (drop_set)      drop_q <= 1'b1;
      else if (drop_clr) drop_q <= 1'b0;

      if (emit) begin
        out_valid <= 1'b1; out_data <= oldest;
        out_sop <= e_sop; out_eop <= e_eop;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      st_valid <= st_fire;
      st_code  <= st_c;
    end
  end
endmodule

// File: rtl/laps_rx_decap_chk.sv
module laps_rx_decap_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sop,
  input logic       out_eop,
  input logic       st_valid,
  input logic [2:0] st_code
);
  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else if (out_valid && out_ready) open_q <= !out_eop;
  end

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
                               && $stable(out_sop) && $stable(out_eop));

  p_sop_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop |-> !open_q);

  p_mid_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sop |-> open_q);

  p_eop_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eop && (!$past(out_valid) || $past(out_ready)) |-> st_valid);

  p_status_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $past(in_valid && in_ready));

  p_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> st_code <= 3'd4);

  p_beat_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$past(out_valid) |-> $past(in_valid && in_ready));
endmodule

bind laps_rx_decap laps_rx_decap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sop(out_sop), .out_eop(out_eop), .st_valid(st_valid), .st_code(st_code)
);

// File: tb/sim_laps_rx_decap.sv
`timescale 1ns/1ps
module sim_laps_rx_decap;
  typedef logic [7:0] bq_t [$];

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_data;
  logic        out_sop, out_eop, st_valid;
  logic [2:0]  st_code;
  logic [7:0]  cfg_addr = 8'h04;
  logic [7:0]  cfg_ctrl = 8'h03;
  logic [15:0] cfg_sapi = 16'hFE01;
  logic [11:0] cfg_max_len = 12'd2000;

  int n_chk = 0, n_fail = 0, cyc = 0, rdy_mode = 0, stall_leak = 0;
  bit done = 1'b0;
  bq_t q_data;
  logic q_sop [$];
  logic q_eop [$];
  int   q_st  [$];

  always #2 clk = ~clk;

  laps_rx_decap u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
    .st_valid(st_valid), .st_code(st_code), .cfg_addr(cfg_addr),
    .cfg_ctrl(cfg_ctrl), .cfg_sapi(cfg_sapi), .cfg_max_len(cfg_max_len)
  );

  initial out_ready = 1'b1;
  always @(posedge clk) begin
    cyc++;
    #1 out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  always @(negedge clk) if (rst_n) begin
    if (out_valid && out_ready) begin
      q_data.push_back(out_data); q_sop.push_back(out_sop); q_eop.push_back(out_eop);
    end
    if (st_valid) q_st.push_back(int'(st_code));
    if (out_valid && !out_ready && in_ready) stall_leak++;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] b);
    for (int i = 0; i < 8; i++) c = (c[0] ^ b[i]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c;
  endfunction

  task automatic clr_mon();
    q_data.delete(); q_sop.delete(); q_eop.delete(); q_st.delete();
  endtask

  task automatic send_byte(logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_raw(bq_t r);
    foreach (r[i]) send_byte(r[i]);
  endtask

  task automatic send_frame(logic [7:0] a, logic [7:0] c, bq_t pl, bit bad_fcs, bit ra);
    bq_t raw;
    logic [31:0] crc, f;
    raw = {a, c, cfg_sapi[15:8], cfg_sapi[7:0]};
    foreach (pl[i]) raw.push_back(pl[i]);
    crc = 32'hFFFFFFFF;
    foreach (raw[i]) crc = crc_step(crc, raw[i]);
    f = ~crc;
    raw.push_back(f[7:0]); raw.push_back(f[15:8]);
    raw.push_back(f[23:16]); raw.push_back(f[31:24]);
    if (bad_fcs) raw[raw.size()-1] = raw[raw.size()-1] ^ 8'h01;
    send_byte(8'h7E);
    foreach (raw[i]) begin
      if (ra && (i % 3 == 1)) begin send_byte(8'h7D); send_byte(8'hDD); end
      if (raw[i] == 8'h7E)      begin send_byte(8'h7D); send_byte(8'h5E); end
      else if (raw[i] == 8'h7D) begin send_byte(8'h7D); send_byte(8'h5D); end
      else send_byte(raw[i]);
    end
    send_byte(8'h7E);
  endtask

  task automatic expect_out(string req, bq_t pl, int code);
    int bad = 0;
    repeat (30) @(posedge clk);
    #1;
    check(q_st.size() == 1, req, "status count", q_st.size(), 1);
    if (q_st.size() == 1) check(q_st[0] == code, req, "status code", q_st[0], code);
    check(q_data.size() == pl.size(), req, "beat count", q_data.size(), pl.size());
    if (q_data.size() == pl.size()) begin
      foreach (pl[i])
        if (q_data[i] != pl[i] || q_sop[i] != (i == 0) || q_eop[i] != (i == pl.size() - 1)) bad++;
      check(bad == 0, req, "beat content/markers mismatches", bad, 0);
    end
    clr_mon();
  endtask

  task automatic t_reset();
    #1;
    check(in_ready == 1'b1, "R10", "in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R10", "out_valid", out_valid, 0);
    check(st_valid == 1'b0, "R10", "st_valid", st_valid, 0);
  endtask

  task automatic t_good_escapes();
    bq_t pl = {8'h11, 8'h7E, 8'h22, 8'h7D, 8'h33, 8'h44};
    send_frame(cfg_addr, cfg_ctrl, pl, 1'b0, 1'b0);
    expect_out("R2_R6", pl, 0);
  endtask

  task automatic t_rate_adapt();
    bq_t pl = {8'hA1, 8'h7D, 8'hB2, 8'hC3, 8'h7E, 8'hD4, 8'hE5};
    send_frame(cfg_addr, cfg_ctrl, pl, 1'b0, 1'b1);
    expect_out("R3", pl, 0);
  endtask

  task automatic t_idle();
    bq_t pl = {8'h5A};
    bq_t none;
    send_raw({8'h7E, 8'h7E, 8'h7E, 8'h7E, 8'h7E});
    expect_out_none("R1");
    send_byte(8'h7E);
    send_frame(cfg_addr, cfg_ctrl, pl, 1'b0, 1'b0);
    expect_out("R1_R8", pl, 0);
    none = {};
  endtask

  task automatic expect_out_none(string req);
    repeat (20) @(posedge clk);
    #1;
    check(q_st.size() == 0, req, "status count", q_st.size(), 0);
    check(q_data.size() == 0, req, "beat count", q_data.size(), 0);
    clr_mon();
  endtask

  task automatic t_bad_fcs();
    bq_t pl = {8'h01, 8'h02, 8'h03};
    send_frame(cfg_addr, cfg_ctrl, pl, 1'b1, 1'b0);
    expect_out("R6", pl, 2);
  endtask

  task automatic t_bad_header();
    bq_t pl = {8'h01, 8'h02, 8'h03};
    bq_t none;
    send_frame(cfg_addr, 8'h13, pl, 1'b0, 1'b0);
    none = {};
    expect_out("R5", none, 1);
  endtask

  task automatic t_abort_flag();
    bq_t exp = {8'hA0, 8'hA1, 8'hA2, 8'hA3};
    bq_t pl = {8'h66};
    send_raw({8'h7E, 8'h04, 8'h03, 8'hFE, 8'h01, 8'hA0, 8'hA1, 8'hA2, 8'hA3,
              8'hA4, 8'hA5, 8'hA6, 8'hA7, 8'h7D, 8'h7E, 8'h55, 8'h66, 8'h7E});
    expect_out("R4", exp, 3);
    send_frame(cfg_addr, cfg_ctrl, pl, 1'b0, 1'b0);
    expect_out("R4", pl, 0);
  endtask

  task automatic t_abort_unknown();
    bq_t none;
    send_raw({8'h7E, 8'h04, 8'h03, 8'hFE, 8'h01, 8'hA0, 8'hA1, 8'h7D, 8'h41,
              8'hB0, 8'hB1, 8'h7E});
    none = {};
    expect_out("R4", none, 3);
  endtask

  task automatic t_oversize();
    bq_t pl  = {8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6, 8'hC7, 8'hC8, 8'hC9};
    bq_t exp = {8'hC0, 8'hC1, 8'hC2, 8'hC3};
    cfg_max_len = 12'd12;
    send_frame(cfg_addr, cfg_ctrl, pl, 1'b0, 1'b0);
    expect_out("R7", exp, 4);
    send_frame(cfg_addr, cfg_ctrl, exp, 1'b0, 1'b0);
    expect_out("R7", exp, 0);
    cfg_max_len = 12'd2000;
  endtask

  task automatic t_short();
    bq_t none;
    none = {};
    send_raw({8'h7E, 8'h04, 8'h03, 8'h7E});
    expect_out("R11", none, 1);
    send_raw({8'h7E, 8'h04, 8'h03, 8'hFE, 8'h01, 8'h55, 8'h66, 8'h7E});
    expect_out("R11", none, 2);
  endtask

  task automatic t_backpressure();
    bq_t pl;
    for (int i = 0; i < 20; i++) pl.push_back(8'(i * 13 + 8'h70));
    rdy_mode = 1;
    stall_leak = 0;
    send_frame(cfg_addr, cfg_ctrl, pl, 1'b0, 1'b1);
    expect_out("R9", pl, 0);
    send_frame(cfg_addr, cfg_ctrl, pl, 1'b1, 1'b0);
    expect_out("R9", pl, 2);
    check(stall_leak == 0, "R9", "in_ready high while output stalled", stall_leak, 0);
    rdy_mode = 0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 1 expected 0");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_good_escapes();
    t_rate_adapt();
    t_idle();
    t_bad_fcs();
    t_bad_header();
    t_abort_flag();
    t_abort_unknown();
    t_oversize();
    t_short();
    t_backpressure();
    done = 1'b1;
    report();
  end
endmodule